// File: doc/BRIEF.md
# Hashed Tag Store with Chained Overflow

This block is the tag lookup engine of a fully associative cache whose tags are kept in a hash table. Each address divides into a block offset and a tag. A fold of the tag picks one set of a small primary table, and every way of that set is compared in parallel. When none of them holds the tag, the engine follows a pointer-linked chain of overflow entries in a secondary tag memory. It reads one chain entry per clock cycle until the tag turns up or the chain runs out. Every lookup reports whether it hit, which tag slot matched, how many hash probes it took and the access latency those probes imply.

The same request port also carries the maintenance operations that a replacement controller needs. It can place a tag in a free primary way or drop one from a way. It can move a way to the most-recent or the least-recent end of its set's order. It can read and clear a way's referenced flag. It can push a tag onto a set's overflow chain, which takes an entry from the free list, or pop the newest entry of a chain, which returns that entry to the free list. Requests use a valid/ready handshake and are taken only while the engine is idle. Each accepted request produces exactly one single-cycle response.

Top module: `hashed_tag_store`

## Requirements
- R1: The tag is `req_addr >> OFF_W`. Each response returns the low OFF_W address bits on `rsp_off` and the block base (the tag shifted back up by OFF_W, with zero offset bits) on `rsp_base`.
- R2: The set index is the XOR fold of the tag: tag bit i is XORed into set bit (i mod SET_W). A lookup (op 0) hits in the primary table only on a way whose valid flag is set and whose stored tag is equal. The lowest matching position wins. The result is reported as `rsp_idx = set*WAYS + position` with depth 1.
- R3: When the primary set misses, the lookup walks that set's overflow chain starting at the newest entry. A secondary hit reports `rsp_idx = PRI_N + entry`, where PRI_N = SETS*WAYS. A miss reports `rsp_hit = 0` and `rsp_idx = 0`.
- R4: `rsp_depth` is 1 for a lookup settled in the primary table. It grows by one for each chain entry examined, so a miss on a chain of n entries reports 1+n. Operations other than lookup report depth 0.
- R5: `rsp_lat = HIT_LAT + HASH_DLY * rsp_depth` on every response.
- R6: Position 0 of a set is its most recently used way. A primary lookup hit moves the hit way to position 0, shifts the ways that were ahead of it down by one, and sets its referenced flag. Op 5 moves the way at position `req_way` to position 0 and reports `rsp_idx = set*WAYS`. Op 6 moves it to position WAYS-1, shifting the later ways up, and reports `rsp_idx = set*WAYS + WAYS-1`. Both report `rsp_hit = 1`.
- R7: Op 1 places the tag, valid and unreferenced, in the lowest-numbered invalid way and reports its index with `rsp_hit = 1`. If the set is full it reports `rsp_hit = 0`, `rsp_idx = 0` and changes nothing. Op 4 clears the valid flag at position `req_way` and reports its previous value on `rsp_hit`.
- R8: Free secondary entries form a last-in first-out list, and after reset it hands out entries 0, 1, 2, … in ascending order. Op 2 takes the head of the free list, writes the tag into it and links it as the newest entry of the set's chain, reporting `rsp_idx = PRI_N + entry`. Op 3 unlinks the newest entry of the set's chain and puts it at the head of the free list, reporting its index. An empty free list (op 2) or an empty chain (op 3) gives `rsp_hit = 0` and changes nothing.
- R9: Op 7 reports the referenced flag of the way at position `req_way` on `rsp_hit`, then clears that flag. It reports `rsp_idx = set*WAYS + req_way`.
- R10: `req_ready` is low from reset until SEC_N cycles after reset is released, and it is low while a chain is being walked. Each accepted request gives exactly one `rsp_valid` pulse.
- R11: While reset is asserted `rsp_valid` is low. After reset every way is invalid and every chain is empty, so a first lookup misses with depth 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request will be taken |
| req_op | input | 3 | Operation code (0 lookup, 1 primary insert, 2 chain push, 3 chain pop, 4 way invalidate, 5 move to head, 6 move to tail, 7 clear reference) |
| req_addr | input | ADDR_W | Byte address; its tag selects the set |
| req_way | input | POS_W | Recency position for ops 4 to 7 |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | Hit or success flag, or the old flag value for ops 4 and 7 |
| rsp_idx | output | IDX_W | Tag slot: primary set*WAYS+position, or PRI_N+secondary entry |
| rsp_depth | output | DEP_W | Number of hash probes made |
| rsp_lat | output | LAT_W | Access latency derived from the depth |
| rsp_off | output | OFF_W | Block offset of the request address |
| rsp_base | output | ADDR_W | Block-aligned base address |

## Verification
The assertions check on every cycle that the latency follows the depth and that every walk step adds exactly one probe. They also check that a depth above one never reports a primary slot, that ready falls when a walk starts, that no more than one request is ever in flight, and that the free-list and chain pointers stay within range. Inside the primary table they check that a hit way arrives at position 0 with its reference flag set, that an inserted way becomes valid and that a cleared reference stays clear. Only the bench scenarios can show the orderings: which free way is chosen, the newest-first walk order, the last-in first-out reuse of freed entries, exhaustion of the free list, and the exact reshuffling done by the head and tail moves. These are checked against a reference model.

// File: rtl/htc_pkg.sv
package htc_pkg;
  typedef enum logic [2:0] {
    OP_LOOKUP = 3'd0,
    OP_PINS   = 3'd1,
    OP_SPUSH  = 3'd2,
    OP_SPOP   = 3'd3,
    OP_PINV   = 3'd4,
    OP_HEAD   = 3'd5,
    OP_TAIL   = 3'd6,
    OP_CLRREF = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_INIT = 2'd0,
    ST_IDLE = 2'd1,
    ST_WALK = 2'd2,
    ST_UPD  = 2'd3
  } st_e;
endpackage

// File: rtl/htc_hash_fold.sv
module htc_hash_fold #(
  parameter int IN_W  = 12,
  parameter int OUT_W = 2
) (
  input  logic [IN_W-1:0]  in_i,
  output logic [OUT_W-1:0] out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < IN_W; i++) begin
      out_o[i % OUT_W] = out_o[i % OUT_W] ^ in_i[i];
    end
  end
endmodule

// File: rtl/htc_sec_ram.sv
module htc_sec_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 17,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/htc_primary.sv
module htc_primary
  import htc_pkg::*;
#(
  parameter int SETS  = 4,
  parameter int WAYS  = 4,
  parameter int TAG_W = 12,
  localparam int SET_W = $clog2(SETS),
  localparam int POS_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] set_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [POS_W-1:0] way_i,
  input  op_e              op_i,
  input  logic             apply_i,
  output logic             hit_o,
  output logic [POS_W-1:0] hit_pos_o,
  output logic             free_ok_o,
  output logic [POS_W-1:0] free_pos_o,
  output logic             sel_v_o,
  output logic             sel_r_o
);
  typedef struct packed {
    logic             v;
    logic             r;
    logic [TAG_W-1:0] tag;
  } ent_t;

  ent_t tbl [SETS][WAYS];
  ent_t row  [WAYS];
  ent_t nrow [WAYS];
  logic row_wr;
  logic do_head, do_tail;
  logic [POS_W-1:0] k;

  always_comb begin
    hit_o = 1'b0;
    hit_pos_o = '0;
    free_ok_o = 1'b0;
    free_pos_o = '0;
    for (int p = WAYS-1; p >= 0; p--) begin
      row[p] = tbl[set_i][p];
      if (tbl[set_i][p].v && tbl[set_i][p].tag == tag_i) begin
        hit_o = 1'b1;
        hit_pos_o = POS_W'(p);
      end
      if (!tbl[set_i][p].v) begin
        free_ok_o = 1'b1;
        free_pos_o = POS_W'(p);
      end
    end
    sel_v_o = tbl[set_i][way_i].v;
    sel_r_o = tbl[set_i][way_i].r;
  end

  always_comb begin
    do_head = (op_i == OP_LOOKUP && hit_o) || (op_i == OP_HEAD);
    do_tail = (op_i == OP_TAIL);
    k = (op_i == OP_LOOKUP) ? hit_pos_o : way_i;
    row_wr = 1'b0;
    for (int p = 0; p < WAYS; p++) nrow[p] = row[p];
    if (do_head) begin
      row_wr = 1'b1;
      for (int p = 0; p < WAYS; p++) begin
        if (p == 0) nrow[p] = row[k];
        else if (p <= int'(k)) nrow[p] = row[p-1];
      end
      if (op_i == OP_LOOKUP) nrow[0].r = 1'b1;
    end else if (do_tail) begin
      row_wr = 1'b1;
      for (int p = 0; p < WAYS; p++) begin
        if (p == WAYS-1) nrow[p] = row[k];
        else if (p >= int'(k)) nrow[p] = row[p+1];
      end
    end else begin
      case (op_i)
        OP_PINS: begin
          if (free_ok_o) begin
            row_wr = 1'b1;
            nrow[free_pos_o] = '{v: 1'b1, r: 1'b0, tag: tag_i};
          end
        end
        OP_PINV: begin
          row_wr = 1'b1;
          nrow[way_i].v = 1'b0;
        end
        OP_CLRREF: begin
          row_wr = 1'b1;
          nrow[way_i].r = 1'b0;
        end
        default: row_wr = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < SETS; s++)
        for (int p = 0; p < WAYS; p++)
          tbl[s][p] <= '0;
    end else if (apply_i && row_wr) begin
      for (int p = 0; p < WAYS; p++) tbl[set_i][p] <= nrow[p];
    end
  end

  // checker state: request fields of the previous cycle
  logic [SET_W-1:0] set_q;
  logic [TAG_W-1:0] tag_q;
  logic [POS_W-1:0] way_q;
  logic [POS_W-1:0] fpos_q;
  always_ff @(posedge clk) begin
    set_q  <= set_i;
    tag_q  <= tag_i;
    way_q  <= way_i;
    fpos_q <= free_pos_o;
  end

  // R6: a lookup hit leaves the tag at the most recent position, referenced
  a_r6_hit_to_head: assert property (@(posedge clk) disable iff (rst)
    apply_i && op_i == OP_LOOKUP && hit_o |=>
      tbl[set_q][0].v && tbl[set_q][0].r && tbl[set_q][0].tag == tag_q);

  // R7: an accepted insert into a set with room makes that way valid
  a_r7_insert_valid: assert property (@(posedge clk) disable iff (rst)
    apply_i && op_i == OP_PINS && free_ok_o |=>
      tbl[set_q][fpos_q].v && tbl[set_q][fpos_q].tag == tag_q);

  // R9: after a clear-reference the flag reads low
  a_r9_ref_cleared: assert property (@(posedge clk) disable iff (rst)
    apply_i && op_i == OP_CLRREF |=> !tbl[set_q][way_q].r);
endmodule

// File: rtl/hashed_tag_store.sv
module hashed_tag_store
  import htc_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFF_W    = 4,
  parameter int SETS     = 4,
  parameter int WAYS     = 4,
  parameter int SEC_N    = 16,
  parameter int HIT_LAT  = 2,
  parameter int HASH_DLY = 3,
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int SET_W  = $clog2(SETS),
  localparam int POS_W  = $clog2(WAYS),
  localparam int PRI_N  = SETS * WAYS,
  localparam int SEC_AW = $clog2(SEC_N),
  localparam int PTR_W  = $clog2(SEC_N + 1),
  localparam int IDX_W  = $clog2(PRI_N + SEC_N),
  localparam int DEP_W  = $clog2(SEC_N + 2),
  localparam int LAT_W  = $clog2(HIT_LAT + HASH_DLY * (SEC_N + 1) + 1),
  localparam int ENT_W  = TAG_W + PTR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [POS_W-1:0]  req_way,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic [DEP_W-1:0]  rsp_depth,
  output logic [LAT_W-1:0]  rsp_lat,
  output logic [OFF_W-1:0]  rsp_off,
  output logic [ADDR_W-1:0] rsp_base
);
  localparam logic [PTR_W-1:0] NULLP = PTR_W'(SEC_N);

  st_e state;
  logic [PTR_W-1:0] chain [SETS];
  logic [PTR_W-1:0] fhead, cur, steps;
  logic [DEP_W-1:0] depth;
  logic [SET_W-1:0] set_r;
  logic [TAG_W-1:0] tag_r;
  op_e              op_r;
  logic [ADDR_W-1:0] addr_r;
  logic [SEC_AW-1:0] init_cnt;

  op_e              req_opc;
  logic             accept;
  logic [TAG_W-1:0] req_tag;
  logic [SET_W-1:0] req_set;
  logic [PTR_W-1:0] head_req;

  logic             pri_hit, pri_free_ok, pri_sel_v, pri_sel_r;
  logic [POS_W-1:0] pri_hit_pos, pri_free_pos;

  logic              rd_en, wr_en;
  logic [SEC_AW-1:0] rd_addr, wr_addr;
  logic [ENT_W-1:0]  wr_data, rd_q;
  logic [TAG_W-1:0]  rd_tag;
  logic [PTR_W-1:0]  rd_next;

  logic              rv_n, rh_n;
  logic [IDX_W-1:0]  ri_n;
  logic [DEP_W-1:0]  dn_n;
  logic [ADDR_W-1:0] src_addr;

  assign req_opc   = op_e'(req_op);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign req_tag   = req_addr[ADDR_W-1:OFF_W];
  assign head_req  = chain[req_set];
  assign rd_tag    = rd_q[ENT_W-1:PTR_W];
  assign rd_next   = rd_q[PTR_W-1:0];

  function automatic logic [IDX_W-1:0] pidx(input logic [SET_W-1:0] s,
                                            input logic [POS_W-1:0] p);
    return IDX_W'(s) * IDX_W'(WAYS) + IDX_W'(p);
  endfunction

  function automatic logic [IDX_W-1:0] sidx(input logic [PTR_W-1:0] e);
    return IDX_W'(PRI_N) + IDX_W'(e);
  endfunction

  function automatic logic [LAT_W-1:0] lat_of(input logic [DEP_W-1:0] d);
    return LAT_W'(HIT_LAT) + LAT_W'(HASH_DLY) * LAT_W'(d);
  endfunction

  htc_hash_fold #(.IN_W(TAG_W), .OUT_W(SET_W)) u_hash (
    .in_i (req_tag),
    .out_o(req_set)
  );

  htc_primary #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_primary (
    .clk       (clk),
    .rst       (rst),
    .set_i     (req_set),
    .tag_i     (req_tag),
    .way_i     (req_way),
    .op_i      (req_opc),
    .apply_i   (accept),
    .hit_o     (pri_hit),
    .hit_pos_o (pri_hit_pos),
    .free_ok_o (pri_free_ok),
    .free_pos_o(pri_free_pos),
    .sel_v_o   (pri_sel_v),
    .sel_r_o   (pri_sel_r)
  );

  htc_sec_ram #(.DEPTH(SEC_N), .W(ENT_W)) u_sec (
    .clk    (clk),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .rd_en  (rd_en),
    .rd_addr(rd_addr),
    .rd_data(rd_q)
  );

  always_comb begin
    rv_n = 1'b0;
    rh_n = 1'b0;
    ri_n = '0;
    dn_n = '0;
    src_addr = addr_r;
    rd_en = 1'b0;
    rd_addr = '0;
    wr_en = 1'b0;
    wr_addr = '0;
    wr_data = '0;
    case (state)
      ST_INIT: begin
        wr_en = 1'b1;
        wr_addr = init_cnt;
        wr_data = {TAG_W'(0), PTR_W'(init_cnt) + PTR_W'(1)};
      end
      ST_IDLE: begin
        src_addr = req_addr;
        if (accept) begin
          case (req_opc)
            OP_LOOKUP: begin
              if (pri_hit) begin
                rv_n = 1'b1; rh_n = 1'b1;
                ri_n = pidx(req_set, pri_hit_pos);
                dn_n = DEP_W'(1);
              end else if (head_req == NULLP) begin
                rv_n = 1'b1;
                dn_n = DEP_W'(1);
              end else begin
                rd_en = 1'b1;
                rd_addr = head_req[SEC_AW-1:0];
              end
            end
            OP_PINS: begin
              rv_n = 1'b1;
              rh_n = pri_free_ok;
              ri_n = pri_free_ok ? pidx(req_set, pri_free_pos) : '0;
            end
            OP_SPUSH: begin
              if (fhead == NULLP) rv_n = 1'b1;
              else begin
                rd_en = 1'b1;
                rd_addr = fhead[SEC_AW-1:0];
              end
            end
            OP_SPOP: begin
              if (head_req == NULLP) rv_n = 1'b1;
              else begin
                rd_en = 1'b1;
                rd_addr = head_req[SEC_AW-1:0];
              end
            end
            OP_PINV: begin
              rv_n = 1'b1; rh_n = pri_sel_v;
              ri_n = pidx(req_set, req_way);
            end
            OP_HEAD: begin
              rv_n = 1'b1; rh_n = 1'b1;
              ri_n = pidx(req_set, '0);
            end
            OP_TAIL: begin
              rv_n = 1'b1; rh_n = 1'b1;
              ri_n = pidx(req_set, POS_W'(WAYS-1));
            end
            default: begin
              rv_n = 1'b1; rh_n = pri_sel_r;
              ri_n = pidx(req_set, req_way);
            end
          endcase
        end
      end
      ST_WALK: begin
        if (rd_tag == tag_r) begin
          rv_n = 1'b1; rh_n = 1'b1;
          ri_n = sidx(cur);
          dn_n = depth + DEP_W'(1);
        end else if (rd_next == NULLP || steps == PTR_W'(SEC_N-1)) begin
          rv_n = 1'b1;
          dn_n = depth + DEP_W'(1);
        end else begin
          rd_en = 1'b1;
          rd_addr = rd_next[SEC_AW-1:0];
        end
      end
      default: begin
        rv_n = 1'b1; rh_n = 1'b1;
        ri_n = sidx(cur);
        wr_en = 1'b1;
        wr_addr = cur[SEC_AW-1:0];
        wr_data = (op_r == OP_SPUSH) ? {tag_r, chain[set_r]} : {rd_tag, fhead};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_INIT;
      init_cnt <= '0;
      fhead <= '0;
      for (int s = 0; s < SETS; s++) chain[s] <= NULLP;
      cur <= '0;
      steps <= '0;
      depth <= '0;
      set_r <= '0;
      tag_r <= '0;
      op_r <= OP_LOOKUP;
      addr_r <= '0;
      rsp_valid <= 1'b0;
      rsp_hit <= 1'b0;
      rsp_idx <= '0;
      rsp_depth <= '0;
      rsp_lat <= '0;
      rsp_off <= '0;
      rsp_base <= '0;
    end else begin
      rsp_valid <= rv_n;
      rsp_hit   <= rh_n;
      rsp_idx   <= ri_n;
      rsp_depth <= dn_n;
      rsp_lat   <= lat_of(dn_n);
      rsp_off   <= src_addr[OFF_W-1:0];
      rsp_base  <= {src_addr[ADDR_W-1:OFF_W], OFF_W'(0)};
      case (state)
        ST_INIT: begin
          init_cnt <= init_cnt + SEC_AW'(1);
          if (init_cnt == SEC_AW'(SEC_N-1)) state <= ST_IDLE;
        end
        ST_IDLE: begin
          if (accept) begin
            set_r <= req_set;
            tag_r <= req_tag;
            op_r <= req_opc;
            addr_r <= req_addr;
            depth <= DEP_W'(1);
            steps <= '0;
            if (rd_en) begin
              cur <= (req_opc == OP_SPUSH) ? fhead : head_req;
              state <= (req_opc == OP_LOOKUP) ? ST_WALK : ST_UPD;
            end
          end
        end
        ST_WALK: begin
          if (rd_en) begin
            cur <= rd_next;
            depth <= depth + DEP_W'(1);
            steps <= steps + PTR_W'(1);
          end else begin
            state <= ST_IDLE;
          end
        end
        default: begin
          if (op_r == OP_SPUSH) begin
            fhead <= rd_next;
            chain[set_r] <= cur;
          end else begin
            chain[set_r] <= rd_next;
            fhead <= cur;
          end
          state <= ST_IDLE;
        end
      endcase
    end
  end

  // checker: requests in flight
  logic [1:0] pend;
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else pend <= pend + 2'(accept) - 2'(rv_n);
  end

  // R5: latency tracks the reported probe depth
  a_r5_latency: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_lat == LAT_W'(HIT_LAT) + LAT_W'(HASH_DLY) * LAT_W'(rsp_depth));

  // R4: each walk cycle adds exactly one probe
  a_r4_walk_step: assert property (@(posedge clk) disable iff (rst)
    state == ST_WALK |=>
      (state == ST_WALK && depth == $past(depth) + DEP_W'(1)) ||
      (rsp_valid && rsp_depth == $past(depth) + DEP_W'(1)));

  // R3: a hit found past the primary table names a secondary slot
  a_r3_sec_slot: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_hit && rsp_depth > DEP_W'(1) |-> rsp_idx >= IDX_W'(PRI_N));

  // R10: starting a chain walk drops ready
  a_r10_busy_walk: assert property (@(posedge clk) disable iff (rst)
    accept && req_opc == OP_LOOKUP && !pri_hit && head_req != NULLP |=> !req_ready);

  // R10: never more than one request awaiting its response
  a_r10_one_in_flight: assert property (@(posedge clk) disable iff (rst)
    pend <= 2'd1);

  // R8: list pointers stay within the entries or the null value
  a_r8_ptr_range: assert property (@(posedge clk) disable iff (rst)
    fhead <= NULLP && cur <= NULLP);

  // R1: the reported base never carries offset bits
  a_r1_base_aligned: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> rsp_base[OFF_W-1:0] == '0);
endmodule

// File: tb/hashed_tag_store_tb_top.sv
`timescale 1ns/1ps
module hashed_tag_store_tb_top;
  localparam int SETS = 4, WAYS = 4, SEC_N = 16, PRI_N = 16;
  localparam int HIT_LAT = 2, HASH_DLY = 3, NUL = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_op = '0;
  logic [15:0] req_addr = '0;
  logic [1:0] req_way = '0;
  logic rsp_valid, rsp_hit;
  logic [4:0] rsp_idx, rsp_depth;
  logic [5:0] rsp_lat;
  logic [3:0] rsp_off;
  logic [15:0] rsp_base;

  always #4 clk = ~clk;

  hashed_tag_store dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_way(req_way),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx),
    .rsp_depth(rsp_depth), .rsp_lat(rsp_lat), .rsp_off(rsp_off),
    .rsp_base(rsp_base)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  int mv[SETS][WAYS], mr[SETS][WAYS], mt[SETS][WAYS];
  int stag[SEC_N], snext[SEC_N], chain[SETS], fhead;
  bit last_ready_after;

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int hashf(input int t);
    int h = 0;
    for (int i = 0; i < 12; i++) h ^= ((t >> i) & 1) << (i % 2);
    return h;
  endfunction

  function automatic int addr_for(input int s, input int k, input int off);
    int t = (k << 2) & 'hfff;
    t ^= (hashf(t) ^ s);
    return (t << 4) | (off & 15);
  endfunction

  task automatic mv_head(input int s, input int k);
    int ev = mv[s][k], er = mr[s][k], et = mt[s][k];
    for (int p = k; p > 0; p--) begin
      mv[s][p] = mv[s][p-1]; mr[s][p] = mr[s][p-1]; mt[s][p] = mt[s][p-1];
    end
    mv[s][0] = ev; mr[s][0] = er; mt[s][0] = et;
  endtask

  task automatic mv_tail(input int s, input int k);
    int ev = mv[s][k], er = mr[s][k], et = mt[s][k];
    for (int p = k; p < WAYS-1; p++) begin
      mv[s][p] = mv[s][p+1]; mr[s][p] = mr[s][p+1]; mt[s][p] = mt[s][p+1];
    end
    mv[s][WAYS-1] = ev; mr[s][WAYS-1] = er; mt[s][WAYS-1] = et;
  endtask

  task automatic run_op(input int op, input int addr, input int way);
    int tag = (addr >> 4) & 'hfff;
    int s = hashf(tag);
    int eh = 0, ei = 0, ed = 0, n = 0, found = -1, p;
    string rq;
    case (op)
      0: begin
        ed = 1;
        for (int q = WAYS-1; q >= 0; q--) if (mv[s][q] != 0 && mt[s][q] == tag) found = q;
        if (found >= 0) begin
          eh = 1; ei = s*WAYS + found; rq = "R2";
          mv_head(s, found); mr[s][0] = 1;
        end else begin
          rq = "R3"; p = chain[s];
          while (p != NUL) begin
            ed++;
            if (stag[p] == tag) begin eh = 1; ei = PRI_N + p; break; end
            p = snext[p];
          end
        end
      end
      1: begin
        rq = "R7";
        for (int q = WAYS-1; q >= 0; q--) if (mv[s][q] == 0) found = q;
        if (found >= 0) begin
          eh = 1; ei = s*WAYS + found;
          mv[s][found] = 1; mr[s][found] = 0; mt[s][found] = tag;
        end
      end
      2: begin
        rq = "R8";
        if (fhead != NUL) begin
          p = fhead; fhead = snext[p]; stag[p] = tag; snext[p] = chain[s]; chain[s] = p;
          eh = 1; ei = PRI_N + p;
        end
      end
      3: begin
        rq = "R8"; p = chain[s];
        if (p != NUL) begin
          chain[s] = snext[p]; snext[p] = fhead; fhead = p;
          eh = 1; ei = PRI_N + p;
        end
      end
      4: begin
        rq = "R7"; eh = mv[s][way]; ei = s*WAYS + way; mv[s][way] = 0;
      end
      5: begin rq = "R6"; eh = 1; ei = s*WAYS; mv_head(s, way); end
      6: begin rq = "R6"; eh = 1; ei = s*WAYS + WAYS-1; mv_tail(s, way); end
      default: begin
        rq = "R9"; eh = mr[s][way]; ei = s*WAYS + way; mr[s][way] = 0;
      end
    endcase

    @(negedge clk);
    while (!req_ready && n < 300) begin @(negedge clk); n++; end
    req_valid = 1'b1; req_op = 3'(op); req_addr = 16'(addr); req_way = 2'(way);
    @(negedge clk);
    req_valid = 1'b0;
    last_ready_after = req_ready;
    n = 0;
    while (!rsp_valid && n < 300) begin @(negedge clk); n++; end
    if (!rsp_valid) begin
      chk(0, 1, "R10", "response timeout");
    end else begin
      chk(int'(rsp_hit), eh, rq, $sformatf("hit op=%0d", op));
      chk(int'(rsp_idx), ei, rq, $sformatf("idx op=%0d", op));
      chk(int'(rsp_depth), ed, "R4", $sformatf("depth op=%0d", op));
      chk(int'(rsp_lat), HIT_LAT + HASH_DLY*ed, "R5", "latency");
      chk(int'(rsp_off), addr & 15, "R1", "offset");
      chk(int'(rsp_base), addr & 'hfff0, "R1", "base");
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < SETS; s++) begin
      chain[s] = NUL;
      for (int p = 0; p < WAYS; p++) begin mv[s][p] = 0; mr[s][p] = 0; mt[s][p] = 0; end
    end
    for (int e = 0; e < SEC_N; e++) begin stag[e] = 0; snext[e] = e + 1; end
    fhead = 0;

    repeat (4) @(negedge clk);
    chk(int'(rsp_valid), 0, "R11", "rsp_valid in reset");
    chk(int'(req_ready), 0, "R10", "ready in reset");
    rst = 1'b0;
    repeat (15) @(posedge clk);
    @(negedge clk);
    chk(int'(req_ready), 0, "R10", "ready during init");
    @(posedge clk);
    @(negedge clk);
    chk(int'(req_ready), 1, "R10", "ready after init");

    // R11: empty store misses with depth 1
    run_op(0, addr_for(0, 1, 5), 0);
    // R7: fill set 0 then overflow
    for (int k = 1; k <= 5; k++) run_op(1, addr_for(0, k, k), 0);
    // R6: hit moves to head
    run_op(0, addr_for(0, 3, 2), 0);
    run_op(0, addr_for(0, 3, 9), 0);
    // R9: clear reference twice
    run_op(7, addr_for(0, 3, 0), 0);
    run_op(7, addr_for(0, 3, 0), 0);
    run_op(6, addr_for(0, 1, 0), 0);
    run_op(5, addr_for(0, 1, 0), 2);
    run_op(4, addr_for(0, 1, 0), 1);
    run_op(1, addr_for(0, 6, 0), 0);
    // R8: ascending allocation, R3 newest-first walk
    for (int k = 10; k <= 12; k++) run_op(2, addr_for(1, k, 0), 0);
    run_op(0, addr_for(1, 10, 7), 0);
    chk(int'(last_ready_after), 0, "R10", "ready low while walking");
    run_op(0, addr_for(1, 13, 1), 0);
    // R8: freed entry reused first
    run_op(3, addr_for(1, 0, 0), 0);
    run_op(2, addr_for(2, 20, 0), 0);
    // R8: exhaust the free list
    for (int k = 30; k < 44; k++) run_op(2, addr_for(3, k, 0), 0);
    run_op(0, addr_for(3, 99, 0), 0);
    run_op(3, addr_for(0, 0, 0), 0);

    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 10;
      int s = $urandom % SETS;
      int k = $urandom % 8;
      int op = (r < 4) ? 0 : (r == 4) ? 1 : (r == 5) ? 2 : (r == 6) ? 3 :
               (r == 7) ? 4 : (r == 8) ? (5 + ($urandom % 2)) : 7;
      run_op(op, addr_for(s, 50 + k, $urandom % 16), $urandom % WAYS);
    end
    finish_run();
  end
endmodule